// File: doc/BRIEF.md
# Banked Scratchpad with Bank-Conflict Serialization

This block is a scratchpad memory shared by the lanes of one warp. One request carries, for each of 32 lanes, an active flag, a byte address, a write flag and a word of write data. The storage is split into as many banks as there are lanes, and a bank can serve one word per cycle. The block works out which lanes fall into which bank and gives each bank one word per cycle. It repeats this until every active lane has been served, and then pulses `done` with the per-lane read data.

The length of an operation depends on the addresses. It is the largest number of different words that the active lanes need from any one bank. Lanes that name the same word count once: reads of that word share one fetch, and writes to it resolve in a fixed order.

The request side is a valid/ready input. `req_ready` is high only while the block is idle. The request is sampled on the one edge where `req_valid` and `req_ready` are both high. From the cycle after that edge, `req_ready` stays low and the request pins are ignored. Back-pressure reaches the requester only through `req_ready`, and a requester may hold `req_valid` high for as long as it likes. The response side has no back-pressure. `done` is high for one cycle, in the same cycle that `req_ready` returns. `rsp_rdata` keeps its value until the next request is accepted.

Top module: `smem_conflict_serializer`

## Requirements
- R1: A lane's bank is byte address bits [6:2] and its word within the bank is bits [11:7], so global word w = address/4 lives in bank w mod 32. Address bits [1:0] are ignored.
- R2: When every active lane targets a different bank, the operation takes one cycle. `done` is seen one clock after the accepting edge.
- R3: The operation lasts N cycles, where N is the largest count of distinct words requested from a single bank. A request with no active lanes takes one cycle.
- R4: Thirty-two lanes reading one column of a 32-word-pitch row-major tile take 32 cycles. With the pitch padded to 33 words, the same column takes one cycle.
- R5: Active reading lanes that name the same word count as one access, and each of them returns that word.
- R6: A reading lane returns the word's value from before the request, even when another lane of the same request writes that word. Writing lanes return zero read data.
- R7: When several active lanes of one request write the same word, the highest-numbered lane's data is stored.
- R8: `req_ready` is high when idle and goes low on the cycle after acceptance. It stays low until `done`, which is a one-cycle pulse coinciding with `req_ready` rising. Request inputs are ignored while busy.
- R9: Inactive lanes write nothing and return zero read data.
- R10: `rsp_rdata` holds its value from `done` until the next accepted request.
- R11: After reset, `req_ready` is 1, `done` is 0 and `rsp_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_active | input | 32 | Per-lane active flag |
| req_addr | input | 384 | Per-lane byte address, lane i at [12*i +: 12] |
| req_wen | input | 32 | Per-lane write flag |
| req_wdata | input | 1024 | Per-lane write word, lane i at [32*i +: 32] |
| done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 1024 | Per-lane read word, lane i at [32*i +: 32] |

## Verification
The assertions take for granted that the requester follows the handshake: it changes the request only when it is not being accepted, and it never relies on the pins after acceptance. The stimulus drives inputs only on falling edges and drops `req_valid` right after the accepting edge. While the block is busy it scrambles the request pins on purpose, so that the results show they are ignored. Storage is not reset, so the bench fills every word before any read; no check ever sees an uninitialised word.

// File: rtl/smem_pkg.sv
package smem_pkg;
  typedef enum logic {ST_IDLE, ST_BUSY} sm_state_t;
  localparam int WORD_OFS = 2; // byte-to-word shift
endpackage

// File: rtl/smem_bank_pick.sv
// Selects which lanes one bank serves this cycle: the lowest pending lane
// that maps here fixes the word, and every pending lane on that word joins.
module smem_bank_pick #(
  parameter int LANES = 32,
  parameter int BB    = 5,
  parameter int WIW   = 5,
  parameter int DW    = 32,
  parameter int BANK  = 0
) (
  input  logic [LANES-1:0]     pend,
  input  logic [LANES*BB-1:0]  lane_bank,
  input  logic [LANES*WIW-1:0] lane_word,
  input  logic [LANES-1:0]     wen,
  input  logic [LANES*DW-1:0]  wdata,
  output logic [LANES-1:0]     grant,
  output logic [WIW-1:0]       word_sel,
  output logic                 wr_en,
  output logic [DW-1:0]        wr_data
);
  localparam logic [BB-1:0] ID = BB'(BANK);

  logic found;

  always_comb begin
    found    = 1'b0;
    word_sel = '0;
    for (int i = 0; i < LANES; i++) begin
      if (!found && pend[i] && lane_bank[i*BB +: BB] == ID) begin
        found    = 1'b1;
        word_sel = lane_word[i*WIW +: WIW];
      end
    end
  end

  always_comb begin
    grant   = '0;
    wr_en   = 1'b0;
    wr_data = '0;
    for (int i = 0; i < LANES; i++) begin
      grant[i] = found && pend[i] && lane_bank[i*BB +: BB] == ID &&
                 lane_word[i*WIW +: WIW] == word_sel;
      if (grant[i] && wen[i]) begin
        wr_en   = 1'b1;
        wr_data = wdata[i*DW +: DW]; // later lanes override earlier ones
      end
    end
  end
endmodule

// File: rtl/smem_bank_store.sv
// One bank: combinational read, clocked write (read sees the old word).
module smem_bank_store #(
  parameter int WIW = 5,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           we,
  input  logic [WIW-1:0] addr,
  input  logic [DW-1:0]  wd,
  output logic [DW-1:0]  rd
);
  localparam int DEPTH = 1 << WIW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
  end

  assign rd = mem[addr];
endmodule

// File: rtl/smem_conflict_serializer.sv
module smem_conflict_serializer #(
  parameter int LANES = 32,
  parameter int AW    = 12,
  parameter int DW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [LANES-1:0]    req_active,
  input  logic [LANES*AW-1:0] req_addr,
  input  logic [LANES-1:0]    req_wen,
  input  logic [LANES*DW-1:0] req_wdata,
  output logic                done,
  output logic [LANES*DW-1:0] rsp_rdata
);
  import smem_pkg::*;

  localparam int BB  = $clog2(LANES);
  localparam int OFS = WORD_OFS;
  localparam int WIW = AW - OFS - BB;

  sm_state_t state_q;
  logic      busy;
  logic [LANES-1:0]     act_q, wen_q, pend_q, grant_all;
  logic [LANES*BB-1:0]  bank_q;
  logic [LANES*WIW-1:0] word_q;
  logic [LANES*DW-1:0]  wdata_q;
  logic [LANES*OFS-1:0] low_bits;
  logic                 unused_low_bits;
  logic [LANES-1:0]     grant_b [LANES];
  logic [DW-1:0]        rd_b    [LANES];
  logic [DW-1:0]        rd_lane [LANES];

  assign busy      = (state_q == ST_BUSY);
  assign req_ready = (state_q == ST_IDLE);

  for (genvar i = 0; i < LANES; i++) begin : g_lowbits
    assign low_bits[i*OFS +: OFS] = req_addr[i*AW +: OFS];
  end
  assign unused_low_bits = ^low_bits;

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [WIW-1:0] sel;
    logic           we;
    logic [DW-1:0]  wd;

    smem_bank_pick #(.LANES(LANES), .BB(BB), .WIW(WIW), .DW(DW), .BANK(b)) u_pick (
      .pend(pend_q), .lane_bank(bank_q), .lane_word(word_q), .wen(wen_q),
      .wdata(wdata_q), .grant(grant_b[b]), .word_sel(sel), .wr_en(we), .wr_data(wd)
    );

    smem_bank_store #(.WIW(WIW), .DW(DW)) u_store (
      .clk(clk), .we(we && busy), .addr(sel), .wd(wd), .rd(rd_b[b])
    );
  end

  always_comb begin
    grant_all = '0;
    for (int b = 0; b < LANES; b++) grant_all = grant_all | grant_b[b];
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) rd_lane[i] = rd_b[bank_q[i*BB +: BB]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      done      <= 1'b0;
      act_q     <= '0;
      wen_q     <= '0;
      pend_q    <= '0;
      bank_q    <= '0;
      word_q    <= '0;
      wdata_q   <= '0;
      rsp_rdata <= '0;
    end else if (state_q == ST_IDLE) begin
      done <= 1'b0;
      if (req_valid) begin
        for (int i = 0; i < LANES; i++) begin
          bank_q[i*BB +: BB]   <= req_addr[i*AW + OFS +: BB];
          word_q[i*WIW +: WIW] <= req_addr[i*AW + OFS + BB +: WIW];
        end
        act_q     <= req_active;
        wen_q     <= req_wen;
        wdata_q   <= req_wdata;
        pend_q    <= req_active;
        rsp_rdata <= '0;
        state_q   <= ST_BUSY;
      end
    end else begin
      for (int i = 0; i < LANES; i++) begin
        if (grant_all[i] && !wen_q[i]) rsp_rdata[i*DW +: DW] <= rd_lane[i];
      end
      pend_q <= pend_q & ~grant_all;
      if ((pend_q & ~grant_all) == '0) begin
        state_q <= ST_IDLE;
        done    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/smem_conflict_serializer_chk.sv
module smem_conflict_serializer_chk #(
  parameter int LANES = 32,
  parameter int DW    = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                done,
  input logic                busy,
  input logic [LANES-1:0]    pend,
  input logic [LANES-1:0]    act,
  input logic [LANES*DW-1:0] rdata
);
  localparam int CW = $clog2(LANES) + 2;
  localparam logic [CW-1:0] LIM = CW'(LANES);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 1'b1;
    else           run_cnt <= '0;
  end

  // R8
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R8
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  // R3
  pending_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || ($countones(pend) < $countones($past(pend)))));

  // R3
  busy_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_cnt < LIM);

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !(req_valid && req_ready) |=> $stable(rdata));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    // R9
    inactive_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && !act[i] |-> rdata[i*DW +: DW] == '0);
  end
endmodule

bind smem_conflict_serializer smem_conflict_serializer_chk #(.LANES(LANES), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .busy(busy), .pend(pend_q), .act(act_q), .rdata(rsp_rdata)
);

// File: tb/smem_conflict_serializer_test.sv
module smem_conflict_serializer_test;
  localparam int L = 32;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int NW = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready, done;
  logic [L-1:0] req_active, req_wen;
  logic [L*AW-1:0] req_addr;
  logic [L*DW-1:0] req_wdata, rsp_rdata;

  logic          t_act  [L];
  logic          t_wen  [L];
  logic [AW-1:0] t_addr [L];
  logic [DW-1:0] t_wd   [L];
  logic [DW-1:0] got    [L];
  logic [DW-1:0] model  [NW];
  int cyc;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < L; i++) begin
      req_active[i]           = t_act[i];
      req_wen[i]              = t_wen[i];
      req_addr[i*AW +: AW]    = t_addr[i];
      req_wdata[i*DW +: DW]   = t_wd[i];
    end
  end

  smem_conflict_serializer #(.LANES(L), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_active(req_active), .req_addr(req_addr), .req_wen(req_wen),
    .req_wdata(req_wdata), .done(done), .rsp_rdata(rsp_rdata)
  );

  function automatic logic [DW-1:0] pat(int w);
    return 32'h5A00_0000 ^ (w * 32'h0001_0003);
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] a,
                       input logic [DW-1:0] e);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, a, e);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic clear_lanes();
    for (int i = 0; i < L; i++) begin
      t_act[i] = 1'b0; t_wen[i] = 1'b0; t_addr[i] = '0; t_wd[i] = '0;
    end
  endtask

  // Issues the current lane arrays, waits for done, checks read data against
  // the bench model and then applies the writes to the model.
  task automatic do_req(input bit scramble, input string req);
    logic [DW-1:0] exp_rd [L];
    logic          s_act  [L];
    logic          s_wen  [L];
    logic [AW-1:0] s_addr [L];
    logic [DW-1:0] s_wd   [L];
    int bad_lane;
    for (int i = 0; i < L; i++) begin
      s_act[i] = t_act[i]; s_wen[i] = t_wen[i]; s_addr[i] = t_addr[i]; s_wd[i] = t_wd[i];
      exp_rd[i] = (s_act[i] && !s_wen[i]) ? model[s_addr[i][AW-1:2]] : '0;
    end
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (scramble) begin
      check(req_ready == 1'b0, "R8 ready low after accept", {31'b0, req_ready}, 32'd0);
      for (int i = 0; i < L; i++) begin
        t_act[i] = 1'b1; t_wen[i] = 1'b1; t_wd[i] = 32'hDEAD_BEEF; t_addr[i] = AW'(i * 4);
      end
    end
    cyc = 0;
    while (!done && cyc < 100) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
    bad_lane = -1;
    for (int i = 0; i < L; i++) begin
      got[i] = rsp_rdata[i*DW +: DW];
      if (bad_lane < 0 && got[i] !== exp_rd[i]) bad_lane = i;
    end
    if (bad_lane < 0) check(1'b1, req, got[0], exp_rd[0]);
    else check(1'b0, $sformatf("%s lane %0d", req, bad_lane), got[bad_lane], exp_rd[bad_lane]);
    for (int i = 0; i < L; i++) begin
      if (s_act[i] && s_wen[i]) model[s_addr[i][AW-1:2]] = s_wd[i];
    end
  endtask

  task automatic t_reset();
    check(req_ready == 1'b1, "R11 ready after reset", {31'b0, req_ready}, 32'd1);
    check(done == 1'b0, "R11 done after reset", {31'b0, done}, 32'd0);
    check(rsp_rdata == '0, "R11 rdata after reset", rsp_rdata[DW-1:0], 32'd0);
  endtask

  task automatic t_fill();
    for (int r = 0; r < 32; r++) begin
      clear_lanes();
      for (int i = 0; i < L; i++) begin
        t_act[i] = 1'b1; t_wen[i] = 1'b1;
        t_addr[i] = AW'((r * 32 + i) * 4);
        t_wd[i] = pat(r * 32 + i);
      end
      do_req(1'b0, "R2 fill row");
      check(cyc == 1, "R2 fill cycles", cyc, 1);
    end
  endtask

  task automatic t_readback();
    for (int r = 0; r < 32; r += 5) begin
      clear_lanes();
      for (int i = 0; i < L; i++) begin
        t_act[i] = 1'b1;
        t_addr[i] = AW'((r * 32 + i) * 4 + (i % 4)); // R1 low bits ignored
      end
      do_req(1'b0, "R1 readback data");
      check(cyc == 1, "R1 R2 readback cycles", cyc, 1);
    end
  endtask

  task automatic t_stride();
    clear_lanes();
    for (int i = 0; i < L; i++) begin
      t_act[i] = 1'b1; t_addr[i] = AW'((i * 32 + 3) * 4);
    end
    do_req(1'b0, "R4 stride-32 data");
    check(cyc == 32, "R4 stride-32 cycles", cyc, 32);
  endtask

  task automatic t_pad();
    clear_lanes();
    for (int i = 0; i < L; i++) begin
      t_act[i] = 1'b1; t_addr[i] = AW'((i * 33) * 4);
    end
    do_req(1'b0, "R4 pitch-33 data");
    check(cyc == 1, "R4 pitch-33 cycles", cyc, 1);
  endtask

  task automatic t_nway();
    clear_lanes();
    for (int i = 4; i < L; i++) begin
      if (i != 5) begin
        t_act[i] = 1'b1; t_addr[i] = AW'((64 + i) * 4);
      end
    end
    for (int k = 0; k < 4; k++) begin
      t_act[k] = 1'b1; t_addr[k] = AW'((k * 32 + 5) * 4);
    end
    do_req(1'b0, "R3 four-way data");
    check(cyc == 4, "R3 four-way cycles", cyc, 4);
  endtask

  task automatic t_bcast();
    clear_lanes();
    for (int i = 0; i < L; i++) begin
      t_act[i] = 1'b1; t_addr[i] = AW'(7 * 4);
    end
    do_req(1'b0, "R5 broadcast data");
    check(cyc == 1, "R5 broadcast cycles", cyc, 1);
    for (int i = 16; i < L; i++) t_addr[i] = AW'(39 * 4);
    do_req(1'b0, "R5 two-word broadcast data");
    check(cyc == 2, "R5 two-word broadcast cycles", cyc, 2);
  endtask

  task automatic t_rw_same();
    clear_lanes();
    t_act[3] = 1'b1; t_wen[3] = 1'b1; t_addr[3] = AW'(100 * 4); t_wd[3] = 32'hCAFE_0100;
    t_act[10] = 1'b1; t_addr[10] = AW'(100 * 4);
    t_act[11] = 1'b1; t_addr[11] = AW'(100 * 4 + 2);
    do_req(1'b0, "R6 read sees old word");
    check(cyc == 1, "R6 same-word cycles", cyc, 1);
    clear_lanes();
    t_act[0] = 1'b1; t_addr[0] = AW'(100 * 4);
    do_req(1'b0, "R6 write landed");
    check(got[0] == 32'hCAFE_0100, "R6 new word", got[0], 32'hCAFE_0100);
  endtask

  task automatic t_multi_wr();
    clear_lanes();
    t_act[1] = 1'b1;  t_wen[1] = 1'b1;  t_addr[1] = AW'(200 * 4);  t_wd[1] = 32'h1111_0001;
    t_act[30] = 1'b1; t_wen[30] = 1'b1; t_addr[30] = AW'(200 * 4); t_wd[30] = 32'h3333_0030;
    t_act[4] = 1'b1;  t_wen[4] = 1'b1;  t_addr[4] = AW'(200 * 4);  t_wd[4] = 32'h4444_0004;
    t_act[2] = 1'b1;  t_addr[2] = AW'(200 * 4);
    do_req(1'b0, "R7 multi-write request");
    check(cyc == 1, "R7 multi-write cycles", cyc, 1);
    clear_lanes();
    t_act[9] = 1'b1; t_addr[9] = AW'(200 * 4);
    do_req(1'b0, "R7 readback");
    check(got[9] == 32'h3333_0030, "R7 highest lane wins", got[9], 32'h3333_0030);
  endtask

  task automatic t_inactive();
    clear_lanes();
    for (int i = 1; i < L; i++) begin
      t_wen[i] = 1'b1; t_addr[i] = AW'(300 * 4); t_wd[i] = 32'hBAD0_0000 + i;
    end
    t_act[0] = 1'b1; t_addr[0] = AW'(300 * 4);
    do_req(1'b0, "R9 inactive lanes zero");
    check(cyc == 1, "R9 inactive cycles", cyc, 1);
    clear_lanes();
    t_act[31] = 1'b1; t_addr[31] = AW'(300 * 4);
    do_req(1'b0, "R9 no write from inactive");
    check(got[31] == pat(300), "R9 word unchanged", got[31], pat(300));
    clear_lanes();
    do_req(1'b0, "R3 R9 empty request data");
    check(cyc == 1, "R3 empty request cycles", cyc, 1);
  endtask

  task automatic t_handshake();
    logic [L*DW-1:0] snap;
    clear_lanes();
    for (int i = 0; i < L; i++) begin
      t_act[i] = 1'b1; t_addr[i] = AW'((i * 32 + 5) * 4);
    end
    do_req(1'b1, "R8 data with pins scrambled while busy");
    check(cyc == 32, "R8 busy cycles unaffected", cyc, 32);
    check(req_ready == 1'b1, "R8 ready with done", {31'b0, req_ready}, 32'd1);
    snap = rsp_rdata;
    clear_lanes();
    @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", {31'b0, done}, 32'd0);
    repeat (3) @(negedge clk);
    check(rsp_rdata == snap, "R10 rdata held", rsp_rdata[DW-1:0], snap[DW-1:0]);
    clear_lanes();
    for (int i = 0; i < L; i++) begin
      t_act[i] = 1'b1; t_addr[i] = AW'(i * 4);
    end
    do_req(1'b0, "R8 scrambled writes ignored");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    clear_lanes();
    for (int w = 0; w < NW; w++) model[w] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_readback();
    t_stride();
    t_pad();
    t_nway();
    t_bcast();
    t_rw_same();
    t_multi_wr();
    t_inactive();
    t_handshake();
    summary();
  end
endmodule